// File: doc/BRIEF.md
# Heartbeat Watchdog With Early-Warning Pulse

This block watches a software heartbeat line and expects it to change level at least once in every timeout window. When a whole window passes with no change, the block first drives a short active-low warning pulse. One clock later it drives an active-low fault level. The fault level stays low until the heartbeat next changes level. If the heartbeat stays silent, the window restarts at each expiry, so a new warning pulse comes out at the end of every later window.

The window length is a count of clock cycles. It is chosen at run time by a small select input, as a base length shifted left by the select value. The heartbeat passes through a synchronizer, and a change is found by comparing two successive synchronized samples. A level that is held for a full clock period is therefore always seen. While the supervisor reset flag is high, the block is idle: its counters are cleared and all of its outputs are high.

A shutdown latch can be built in by parameter. At each falling edge of the warning pulse it looks at the fault level. The fault level is still low at that moment only when the previous window also ended in a timeout. The latch therefore drops its output on the second timeout in a row with no heartbeat between them. It then holds that output low until the supervisor reset.

Top module: `hbeat_guard`

## Requirements
- R1: While `supReset` is high, `warnPulseN`, `faultN` and `shutdownN` are all 1, the window timer is held at zero, and heartbeat activity has no effect.
- R2: The window length W is `BASE_TIMEOUT << timeoutSel` cycles. With no heartbeat change after reset is released, `warnPulseN` falls on the W-th rising clock edge after release.
- R3: Every heartbeat change restarts the window. This holds for a rise, a fall, and each of the two changes of a one-cycle pulse. A change first sampled on edge E restarts the window on edge E+2, and a pulse then follows on edge E+2+W if the line stays silent.
- R4: Each warning pulse holds `warnPulseN` at 0 for exactly `PULSE_LEN` cycles.
- R5: `faultN` falls exactly one clock cycle after the falling edge of `warnPulseN`.
- R6: `faultN` stays 0 until a heartbeat change. It returns to 1 on edge E+2, where E is the edge that first samples the change.
- R7: If the heartbeat stays silent, a further warning pulse comes every W cycles, counted from the previous pulse, and `faultN` stays 0.
- R8: When a heartbeat change takes effect on the same edge as a window expiry, the change wins. No pulse is issued and no fault is set, and the new window starts at that edge.
- R9: With `SHUTDOWN_EN` set, `shutdownN` falls on the falling edge of a warning pulse if `faultN` is 0 at that edge. In practice this is the second timeout with no heartbeat between. It then stays 0 until `supReset`.
- R10: A heartbeat change between two timeouts clears `faultN`, so the next timeout leaves `shutdownN` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all of the block's logic |
| supReset | input | 1 | Supervisor reset active, high; asynchronous clear of the block |
| heartbeat | input | 1 | Software activity line; any level change counts as activity |
| timeoutSel | input | SEL_W | Window select; window = BASE_TIMEOUT << timeoutSel cycles |
| warnPulseN | output | 1 | Active-low warning pulse, PULSE_LEN cycles, at each window expiry |
| faultN | output | 1 | Active-low fault level, set one cycle after the pulse falls, cleared by a heartbeat change |
| shutdownN | output | 1 | Active-low sticky shutdown after two consecutive timeouts (tied 1 if SHUTDOWN_EN is 0) |

## Verification
The bench places a heartbeat change so that it takes effect on the same edge as the window expiry. A design that let the expiry win there would issue a false pulse and fault. A one-cycle heartbeat pulse is also driven just before a window would run out. A detector that saw only one of its two changes, or missed it entirely, would put out the pulse at the wrong edge. The bench also checks the shutdown latch with and without a heartbeat between two timeouts. A latch that sampled the fault level after it had been updated, instead of before, would shut down on the first timeout. One that reloaded on later pulses would release the shutdown.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic restart;     // zero the window counter
    logic expire;      // window ran out with no activity: start warning pulse
    logic setFault;    // one cycle after expire: drive fault level low
    logic clearFault;  // heartbeat activity: release fault level
  } hbgStrobe_t;
endpackage

// File: rtl/hbg_edge.sv
module hbg_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic supReset,
  input  logic hbIn,
  output logic hbToggle
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic hbPrev;

  always_ff @(posedge clk or posedge supReset) begin
    if (supReset) syncChain[0] <= 1'b0;
    else          syncChain[0] <= hbIn;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : gStage
    always_ff @(posedge clk or posedge supReset) begin
      if (supReset) syncChain[i] <= 1'b0;
      else          syncChain[i] <= syncChain[i-1];
    end
  end

  always_ff @(posedge clk or posedge supReset) begin
    if (supReset) hbPrev <= 1'b0;
    else          hbPrev <= syncChain[SYNC_STAGES-1];
  end

  assign hbToggle = syncChain[SYNC_STAGES-1] ^ hbPrev;
endmodule

// File: rtl/hbg_control.sv
module hbg_control
  import hbg_pkg::*;
(
  input  logic       clk,
  input  logic       supReset,
  input  logic       hbToggle,
  input  logic       windowDone,
  output hbgStrobe_t strb
);
  logic expireNow;
  logic expireD;

  // activity on the expiry edge wins over the timeout
  assign expireNow = windowDone & ~hbToggle;

  always_ff @(posedge clk or posedge supReset) begin
    if (supReset) expireD <= 1'b0;
    else          expireD <= expireNow;
  end

  always_comb begin
    strb.restart    = hbToggle | expireNow;
    strb.expire     = expireNow;
    strb.setFault   = expireD;
    strb.clearFault = hbToggle;
  end
endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int BASE_TIMEOUT = 16,
  parameter int SEL_W        = 2,
  parameter int PULSE_LEN    = 4,
  parameter bit SHUTDOWN_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             supReset,
  input  logic [SEL_W-1:0] timeoutSel,
  input  hbgStrobe_t       strb,
  output logic             windowDone,
  output logic             warnN,
  output logic             faultN,
  output logic             shutN
);
  localparam int MAX_WINDOW = BASE_TIMEOUT << ((1 << SEL_W) - 1);
  localparam int CNT_W      = $clog2(MAX_WINDOW + 1);
  localparam int PLS_W      = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] winLimit;
  logic [PLS_W-1:0] pulseCnt;
  logic             faultLow;

  always_comb winLimit = CNT_W'((BASE_TIMEOUT << timeoutSel) - 1);
  // >= keeps a shrunk window from running past its new limit
  assign windowDone = (winCnt >= winLimit);

  always_ff @(posedge clk or posedge supReset) begin
    if (supReset)          winCnt <= '0;
    else if (strb.restart) winCnt <= '0;
    else                   winCnt <= winCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or posedge supReset) begin
    if (supReset)              pulseCnt <= '0;
    else if (strb.expire)      pulseCnt <= PLS_W'(PULSE_LEN);
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - PLS_W'(1);
  end

  always_ff @(posedge clk or posedge supReset) begin
    if (supReset)             faultLow <= 1'b0;
    else if (strb.clearFault) faultLow <= 1'b0;
    else if (strb.setFault)   faultLow <= 1'b1;
  end

  assign warnN  = (pulseCnt == '0);
  assign faultN = ~faultLow;

  if (SHUTDOWN_EN) begin : gLatch
    logic shutLow;
    // samples the fault level as it stands when the pulse falls
    always_ff @(posedge clk or posedge supReset) begin
      if (supReset)                     shutLow <= 1'b0;
      else if (strb.expire && faultLow) shutLow <= 1'b1;
    end
    assign shutN = ~shutLow;
  end else begin : gNoLatch
    assign shutN = 1'b1;
  end
endmodule

// File: rtl/hbeat_guard.sv
module hbeat_guard
  import hbg_pkg::*;
#(
  parameter int BASE_TIMEOUT = 16,
  parameter int SEL_W        = 2,
  parameter int PULSE_LEN    = 4,
  parameter int SYNC_STAGES  = 2,
  parameter bit SHUTDOWN_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             supReset,
  input  logic             heartbeat,
  input  logic [SEL_W-1:0] timeoutSel,
  output logic             warnPulseN,
  output logic             faultN,
  output logic             shutdownN
);
  logic       hbToggle;
  logic       windowDone;
  hbgStrobe_t strb;

  hbg_edge #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .supReset(supReset), .hbIn(heartbeat), .hbToggle(hbToggle)
  );

  hbg_control uCtrl (
    .clk(clk), .supReset(supReset), .hbToggle(hbToggle),
    .windowDone(windowDone), .strb(strb)
  );

  hbg_datapath #(
    .BASE_TIMEOUT(BASE_TIMEOUT), .SEL_W(SEL_W),
    .PULSE_LEN(PULSE_LEN), .SHUTDOWN_EN(SHUTDOWN_EN)
  ) uDp (
    .clk(clk), .supReset(supReset), .timeoutSel(timeoutSel), .strb(strb),
    .windowDone(windowDone), .warnN(warnPulseN), .faultN(faultN),
    .shutN(shutdownN)
  );
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int PULSE_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic supReset,
  input logic hbIn,
  input logic warnN,
  input logic faultN,
  input logic shutN
);
  logic [15:0] lowRun;

  always_ff @(posedge clk or posedge supReset) begin
    if (supReset)   lowRun <= '0;
    else if (!warnN) lowRun <= lowRun + 16'd1;
    else            lowRun <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    supReset |=> (warnN && faultN && shutN));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (supReset)
    $rose(warnN) |-> (lowRun == 16'(PULSE_LEN)));

  assert_fault_after_pulse_R5: assert property (@(posedge clk) disable iff (supReset)
    $fell(faultN) |-> ($past(warnN, 1) == 1'b0 && $past(warnN, 2) == 1'b1));

  assert_fault_clear_on_beat_R6: assert property (@(posedge clk) disable iff (supReset)
    $rose(faultN) |-> ($past(hbIn, SYNC_STAGES + 1) != $past(hbIn, SYNC_STAGES + 2)));

  assert_shutdown_on_second_R9: assert property (@(posedge clk) disable iff (supReset)
    $fell(shutN) |-> ($fell(warnN) && !faultN));

  assert_shutdown_sticky_R9: assert property (@(posedge clk) disable iff (supReset)
    !shutN |=> !shutN);
endmodule

bind hbeat_guard hbg_checker #(
  .PULSE_LEN(PULSE_LEN), .SYNC_STAGES(SYNC_STAGES)
) uChk (
  .clk(clk), .supReset(supReset), .hbIn(heartbeat),
  .warnN(warnPulseN), .faultN(faultN), .shutN(shutdownN)
);

// File: tb/sim_hbeat_guard.sv
`timescale 1ns/1ps
module sim_hbeat_guard;
  localparam int BASE  = 16;
  localparam int PLEN  = 4;
  localparam int SEL_W = 2;

  // [10:9] select, [8] toggle right after release, [7:0] edge of pulse fall
  localparam logic [10:0] VEC [0:7] = '{
    {2'd0, 1'b0, 8'd16},  {2'd1, 1'b0, 8'd32},
    {2'd2, 1'b0, 8'd64},  {2'd3, 1'b0, 8'd128},
    {2'd0, 1'b1, 8'd19},  {2'd1, 1'b1, 8'd35},
    {2'd2, 1'b1, 8'd67},  {2'd3, 1'b1, 8'd131}
  };

  logic clk = 1'b0;
  logic supReset = 1'b1;
  logic heartbeat = 1'b0;
  logic [SEL_W-1:0] timeoutSel = '0;
  logic warnPulseN, faultN, shutdownN;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hbeat_guard #(.BASE_TIMEOUT(BASE), .SEL_W(SEL_W), .PULSE_LEN(PLEN),
                .SYNC_STAGES(2), .SHUTDOWN_EN(1'b1)) u0 (
    .clk(clk), .supReset(supReset), .heartbeat(heartbeat),
    .timeoutSel(timeoutSel), .warnPulseN(warnPulseN),
    .faultN(faultN), .shutdownN(shutdownN)
  );

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic applyReset(input logic [SEL_W-1:0] sel);
    supReset = 1'b1;
    heartbeat = 1'b0;
    timeoutSel = sel;
    repeat (3) tick();
    supReset = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // vector table: R2 window per select, R3 restart by a change after release
    for (int v = 0; v < 8; v++) begin
      int fall;
      fall = int'(VEC[v][7:0]);
      applyReset(VEC[v][10:9]);
      if (VEC[v][8]) heartbeat = 1'b1;
      for (int e = 1; e <= fall; e++) begin
        tick();
        if (e == fall - 1)
          check($sformatf("R2/R3 vec%0d pulse before expiry", v), warnPulseN, 1'b1);
        if (e == fall) begin
          check($sformatf("R2/R3 vec%0d pulse at expiry", v), warnPulseN, 1'b0);
          check($sformatf("R5 vec%0d fault not yet", v), faultN, 1'b1);
        end
      end
    end

    // R1: idle under reset, heartbeat activity ignored
    supReset = 1'b1;
    timeoutSel = '0;
    for (int e = 0; e < 40; e++) begin
      heartbeat = (e % 3 == 0) ? ~heartbeat : heartbeat;
      tick();
    end
    heartbeat = 1'b0;
    tick();
    tick();
    check("R1 warn in reset", warnPulseN, 1'b1);
    check("R1 fault in reset", faultN, 1'b1);
    check("R1 shutdown in reset", shutdownN, 1'b1);
    supReset = 1'b0;
    // timer held at zero: first pulse still lands on edge 16
    for (int e = 1; e <= 44; e++) begin
      tick();
      if (e == 15) check("R1 timer cleared by reset", warnPulseN, 1'b1);
      if (e == 16) begin
        check("R2 first pulse", warnPulseN, 1'b0);
        check("R5 fault lags pulse", faultN, 1'b1);
      end
      if (e == 17) check("R5 fault one cycle after pulse", faultN, 1'b0);
      if (e == 19) check("R4 pulse still low", warnPulseN, 1'b0);
      if (e == 20) check("R4 pulse ends", warnPulseN, 1'b1);
      if (e == 31) begin
        check("R7 no early second pulse", warnPulseN, 1'b1);
        check("R9 no shutdown after one timeout", shutdownN, 1'b1);
      end
      if (e == 32) begin
        check("R7 second pulse", warnPulseN, 1'b0);
        check("R9 shutdown on second timeout", shutdownN, 1'b0);
      end
      if (e == 40) begin
        check("R6 fault held low", faultN, 1'b0);
        heartbeat = 1'b1;
      end
      if (e == 42) check("R6 fault before clear", faultN, 1'b0);
      if (e == 43) check("R6 fault cleared by change", faultN, 1'b1);
      if (e == 44) check("R9 shutdown sticky", shutdownN, 1'b0);
    end

    // R3: rises, falls and a one-cycle pulse all restart the window
    begin
      logic sawLow;
      sawLow = 1'b0;
      applyReset('0);
      for (int e = 1; e <= 80; e++) begin
        tick();
        if (e < 80 && !warnPulseN) sawLow = 1'b1;
        if (e % 10 == 0 && e <= 50) heartbeat = ~heartbeat;
        if (e == 60) heartbeat = ~heartbeat;
        if (e == 61) heartbeat = ~heartbeat;
        if (e == 79) check("R3 no pulse while active", sawLow, 1'b0);
        if (e == 80) check("R3 pulse after one-cycle beat", warnPulseN, 1'b0);
      end
    end

    // R8: change takes effect on the expiry edge
    applyReset('0);
    for (int e = 1; e <= 32; e++) begin
      tick();
      if (e == 13) heartbeat = 1'b1;
      if (e == 16) check("R8 no pulse on tie", warnPulseN, 1'b1);
      if (e == 17) check("R8 no fault on tie", faultN, 1'b1);
      if (e == 31) check("R8 window restarted at tie", warnPulseN, 1'b1);
      if (e == 32) check("R8 pulse after new window", warnPulseN, 1'b0);
    end

    // R10: beat between timeouts prevents shutdown
    applyReset('0);
    for (int e = 1; e <= 56; e++) begin
      tick();
      if (e == 17) check("R10 fault set", faultN, 1'b0);
      if (e == 20) heartbeat = 1'b1;
      if (e == 23) check("R10 fault cleared", faultN, 1'b1);
      if (e == 39) begin
        check("R10 pulse after restart", warnPulseN, 1'b0);
        check("R10 no shutdown", shutdownN, 1'b1);
      end
      if (e == 40) begin
        check("R10 fault set again", faultN, 1'b0);
        check("R10 still no shutdown", shutdownN, 1'b1);
      end
      if (e == 54) check("R9 shutdown waits", shutdownN, 1'b1);
      if (e == 55) begin
        check("R9 shutdown now", shutdownN, 1'b0);
        check("R7 third pulse", warnPulseN, 1'b0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule